// File: doc/BRIEF.md
# Signed Array Multiplier with Sign-Bit Correction

This block multiplies two two's-complement operands of equal width and returns the full-width two's-complement product in the same cycle. It holds no state and has no clock. Operands enter as raw bit vectors, and the product leaves as a vector twice as wide.

The block does not sign-extend each partial-product row. Each product bit is first formed by an AND gate. Any bit that pairs exactly one operand sign bit with a non-sign bit is then inverted. The bit formed by the two sign bits keeps its true value at weight 2^(2W-2). A fixed correction word adds a one at weight 2^W and another at weight 2^(2W-1). A chain of ripple adder rows adds the correction word and the shifted rows modulo 2^(2W). The same array serves every width from 2 upward, and its cost matches that of an unsigned array of the same size.

Top module: `bw_mult`

## Requirements
- R1: For every pair of operand values, `prod` equals the signed product of `op_x` and `op_y` taken modulo 2^(2W). It is read as a 2W-bit two's-complement number.
- R2: When either operand is zero, `prod` is all zeros.
- R3: The most negative operand times itself gives +2^(2W-2), with no overflow. For W=4 this is 0x40.
- R4: When both operands are nonzero, the top bit of `prod` is the XOR of the two operand top bits.
- R5: When `op_x` is +1, `prod` equals `op_y` sign-extended to 2W bits.
- R6: When `op_x` is -1 (all ones), `prod` equals the negation of the sign-extended `op_y`. For W=4 and `op_y` = 0x8, this gives 0x08.
- R7: `prod` depends only on the present operand values. A new operand pair is reflected within the same clock period, and no earlier pair has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | W | Multiplicand, two's complement |
| op_y | input | W | Multiplier, two's complement |
| prod | output | 2W | Product, two's complement |

## Verification
The block has no registers, so any fault appears at once in `prod` for some operand pair. Which pairs expose it depends on where the fault sits. A missing or misplaced correction one shifts every product by a constant, so the first check already shows it. An inversion that is missing on one cross term shows up only for pairs where that term is set. Covering every pair at the default width therefore exposes each such fault within one pass of 256 cycles. The corner pairs of R3, R5 and R6 are also checked under their own names.

// File: rtl/bw_mult_pkg.sv
package bw_mult_pkg;

    // Correction word: ones at weight 2^n and 2^(2n-1), for an n-bit operand pair.
    function automatic logic [127:0] bw_correction(input int n);
        logic [127:0] v;
        v = '0;
        v[n] = 1'b1;
        v[2*n-1] = 1'b1;
        return v;
    endfunction

    // True when exactly one index is the sign position, so the term enters inverted.
    function automatic logic bw_flip(input int i, input int j, input int n);
        return (i == n-1) != (j == n-1);
    endfunction

endpackage

// File: rtl/bw_pp_gen.sv
module bw_pp_gen
    import bw_mult_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]              x_in,
    input  logic [W-1:0]              y_in,
    output logic [W-1:0][2*W-1:0]     rows
);
    localparam int PW = 2 * W;

    always_comb begin
        rows = '0;
        for (int j = 0; j < W; j++) begin
            for (int i = 0; i < W; i++) begin
                if (bw_flip(i, j, W))
                    rows[j][i+j] = ~(x_in[i] & y_in[j]);
                else
                    rows[j][i+j] = x_in[i] & y_in[j];
            end
        end
    end

    // R3: the sign-by-sign term is uninverted, at column 2W-2
    always_comb begin
        p_sign_term_r3: assert (rows[W-1][PW-2] == (x_in[W-1] & y_in[W-1]))
            else $error("sign-by-sign partial product wrong");
    end

endmodule

// File: rtl/bw_ripple_row.sv
module bw_ripple_row #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] a_in,
    input  logic [PW-1:0] b_in,
    output logic [PW-1:0] s_out
);
    logic [PW-1:0] c;

    assign c[0] = 1'b0;

    for (genvar k = 0; k < PW; k++) begin : g_fa
        assign s_out[k] = a_in[k] ^ b_in[k] ^ c[k];
        if (k < PW-1) begin : g_cy
            assign c[k+1] = (a_in[k] & b_in[k]) | (c[k] & (a_in[k] ^ b_in[k]));
        end
    end

    // R1: each row delivers the modulo-2^PW sum of its two inputs
    always_comb begin
        p_row_sum_r1: assert (s_out == PW'(a_in + b_in))
            else $error("ripple row sum wrong");
    end

endmodule

// File: rtl/bw_mult.sv
module bw_mult
    import bw_mult_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   op_x,
    input  logic [W-1:0]   op_y,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    localparam logic [127:0] CORR_FULL = bw_correction(W);
    localparam logic [PW-1:0] CORR = CORR_FULL[PW-1:0];

    logic [W-1:0][PW-1:0] rows;
    logic [W:0][PW-1:0]   acc;

    bw_pp_gen #(.W(W)) u_pp (
        .x_in (op_x),
        .y_in (op_y),
        .rows (rows)
    );

    assign acc[0] = CORR;

    for (genvar j = 0; j < W; j++) begin : g_row
        bw_ripple_row #(.PW(PW)) u_row (
            .a_in  (acc[j]),
            .b_in  (rows[j]),
            .s_out (acc[j+1])
        );
    end

    assign prod = acc[W];

    logic [PW-1:0] sx, sy;
    assign sx = {{W{op_x[W-1]}}, op_x};
    assign sy = {{W{op_y[W-1]}}, op_y};

    always_comb begin
        p_signed_prod_r1: assert (prod == PW'(sx * sy))
            else $error("product differs from signed multiply");
        if (op_x == '0 || op_y == '0) begin
            p_zero_operand_r2: assert (prod == '0)
                else $error("zero operand gave nonzero product");
        end
        if (op_x != '0 && op_y != '0) begin
            p_product_sign_r4: assert (prod[PW-1] == (op_x[W-1] ^ op_y[W-1]))
                else $error("product sign wrong");
        end
        if (op_x == W'(1)) begin
            p_unit_multiplicand_r5: assert (prod == sy)
                else $error("times one is not identity");
        end
    end

endmodule

// File: tb/sim_bw_mult.sv
module sim_bw_mult;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]  op_x = '0;
    logic [W-1:0]  op_y = '0;
    logic [PW-1:0] prod;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bw_mult #(.W(W)) u0 (
        .op_x (op_x),
        .op_y (op_y),
        .prod (prod)
    );

    function automatic int to_int(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    function automatic logic [PW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        int p;
        p = to_int(a) * to_int(b);
        return PW'(p);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] expv);
        checks++;
        if (prod !== expv) begin
            errors++;
            $display("FAIL %s x=%0h y=%0h actual=%0h expected=%0h", req, op_x, op_y, prod, expv);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        op_x = a;
        op_y = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset-state zero operands", '0);

        // R1 and R7: every pair, new pair each period, compared on every clock
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                apply(W'(a), W'(b));
                check("R1 R7 exhaustive", model(W'(a), W'(b)));
            end
        end

        apply(W'(0), W'(7));   check("R2 zero x", '0);
        apply(W'(9), W'(0));   check("R2 zero y", '0);
        apply(W'(8), W'(8));   check("R3 min times min", 8'h40);
        apply(W'(3), W'(13));  check("R4 mixed sign", 8'hF7);
        apply(W'(14), W'(13)); check("R4 both negative", 8'h06);
        apply(W'(1), W'(8));   check("R5 one times min", 8'hF8);
        apply(W'(1), W'(6));   check("R5 one times six", 8'h06);
        apply(W'(15), W'(8));  check("R6 minus one times min", 8'h08);
        apply(W'(15), W'(5));  check("R6 minus one times five", 8'hFB);
        apply(W'(7), W'(7));   check("R7 after prior pair", 8'h31);
        apply(W'(7), W'(8));   check("R1 max times min", 8'hC8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule